// File: doc/BRIEF.md
# Serial Control Port Register File

This block terminates a four-wire serial control link and holds sixteen 10-bit control registers for the rest of the chip. An external controller frames each transfer by pulling an active-low frame line low. It then clocks 16 bits in, most significant bit first, on a serial clock. When the frame line returns high, the block decodes the word it has collected. The word carries a register address, a direction flag, a reserved bit and a data field. A write updates the addressed register. A read loads the addressed register into the shift register, and the controller collects it during the following frame.

All three serial pins are resynchronized into the system clock domain and edge-detected, so the block has a single clock. The serial output and its pad enable are registered. The enable is low whenever the frame line is high, which lets several devices share one return line. Because bits leave the shift register at the far end, several devices can also be chained output-to-input under one frame line for 16×N serial clocks. A single bit in one register serves as a self-clearing soft reset for the whole register set.

Top module: `ctlport_regfile`

## Requirements
- R1: After reset every register reads zero, and `serOut`, `serOutEn` and `swResetPulse` are all low.
- R2: While `serFrameN` is low, `serIn` is captured on each rising edge of `serClk`, most significant bit first. When the frame closes, the word is decoded as follows: address in bits 15..12, direction in bit 11 (0 = write, 1 = read), reserved in bit 10, data in bits 9..0. A write stores the data in the addressed register.
- R3: A register written by a frame shows its new value on `regFlat` exactly SYNC_STAGES+1 system clock cycles after the rising edge of `serFrameN`, and not before.
- R4: After a read command, the next frame shifts out {address, 1, 0, register data}. The MSB is valid on `serOut` before the first rising edge of `serClk`, and each later bit follows a falling edge of `serClk`.
- R5: While `serFrameN` is high, activity on `serClk` and `serIn` has no effect: registers and the pending read response are unchanged, `serOutEn` is low and `serOut` holds still.
- R6: A frame with fewer than 16 rising serial clock edges changes no register.
- R7: In a frame longer than 16 bits, only the last 16 bits are decoded. Each bit shifted in reappears on `serOut` 16 rising serial clock edges later, which allows daisy chaining.
- R8: A write to address SRST_ADDR (default 0) with data bit SRST_BIT (default 9) set clears every register, including that bit. It also raises `swResetPulse` for exactly one cycle, after the frame has closed.
- R9: A read command changes no register, and the reserved bit has no effect on a write.
- R10: Register k appears on `regFlat[k*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the controller |
| serFrameN | input | 1 | Active-low frame qualifier |
| serIn | input | 1 | Serial command data |
| serOut | output | 1 | Serial return data (read response or pass-through) |
| serOutEn | output | 1 | Pad enable for `serOut`; low means high impedance |
| regFlat | output | 160 | All sixteen registers, register k at bits k*10+9..k*10 |
| swResetPulse | output | 1 | One-cycle pulse when the soft-reset bit is written |

## Verification
Every pin edge takes SYNC_STAGES+1 system clock cycles to act: SYNC_STAGES cycles to cross the synchronizer and one to register the action. Register updates therefore appear on the third clock after the frame line rises, and each `serOut` bit is settled three clocks after the serial clock falls. The bench holds each serial clock phase for four system clocks. It samples `serOut` on the last falling system clock edge before it raises the serial clock, the same point where a real controller would capture the bit. The latency check looks at `regFlat` one cycle before and exactly on the expected cycle. A behavioural model with delay queues for the synchronizer is compared with every output on every clock.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

  // Strobes passed from the frame controller to the datapath, one cycle wide.
  typedef struct packed {
    logic frameStart;  // frame line became active
    logic shiftEn;     // rising serial clock inside a frame
    logic outUpd;      // falling serial clock inside a frame
    logic frameEnd;    // frame line became inactive
    logic commit;      // frameEnd with a full word collected
  } ctl_strobe_t;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[CHAIN_W-WIDTH-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/ctlport_ctrl.sv
module ctlport_ctrl
  import ctlport_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sClk,
  input  logic             sFrameN,
  output ctl_strobe_t      st,
  output logic [CNT_W-1:0] bitCnt
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic clkPrev;
  logic framePrev;
  logic active;
  logic riseS;
  logic fallS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      framePrev <= 1'b1;
    end else begin
      clkPrev   <= sClk;
      framePrev <= sFrameN;
    end
  end

  assign active = ~sFrameN;
  assign riseS  = sClk & ~clkPrev & active;
  assign fallS  = ~sClk & clkPrev & active;

  always_comb begin
    st            = '0;
    st.frameStart = active & framePrev;
    st.frameEnd   = sFrameN & ~framePrev;
    st.shiftEn    = riseS;
    st.outUpd     = fallS;
    st.commit     = st.frameEnd & (bitCnt == FULL);
  end

  // Saturating count of rising edges in the current frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (st.frameStart) begin
      bitCnt <= riseS ? CNT_W'(1) : '0;
    end else if (riseS && bitCnt != FULL) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ctlport_dpath.sv
module ctlport_dpath
  import ctlport_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter int SRST_ADDR = 0,
  parameter int SRST_BIT = 9,
  localparam int FRAME_BITS = ADDR_W + 2 + DATA_W,
  localparam int NUM_REGS = 1 << ADDR_W,
  localparam int FLAT_W = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       st,
  input  logic              sIn,
  output logic              serOut,
  output logic              serOutEn,
  output logic [FLAT_W-1:0] regFlat,
  output logic              swResetPulse
);

  localparam int DIR_POS = DATA_W + 1;

  logic [FRAME_BITS-1:0] shReg;
  logic [ADDR_W-1:0]     cmdAddr;
  dir_e                  cmdDir;
  logic [DATA_W-1:0]     cmdData;
  logic [DATA_W-1:0]     rdData;
  logic                  doWrite;
  logic                  doRead;
  logic                  wantReset;

  assign cmdAddr   = shReg[FRAME_BITS-1 -: ADDR_W];
  assign cmdDir    = dir_e'(shReg[DIR_POS]);
  assign cmdData   = shReg[DATA_W-1:0];
  assign doWrite   = st.commit & (cmdDir == DIR_WRITE);
  assign doRead    = st.commit & (cmdDir == DIR_READ);
  assign wantReset = doWrite & (cmdAddr == ADDR_W'(SRST_ADDR)) & cmdData[SRST_BIT];
  assign rdData    = regFlat[cmdAddr*DATA_W +: DATA_W];

  // Register set, one storage element per address.
  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [DATA_W-1:0] regVal;
      logic              wrHit;
      assign wrHit = doWrite & (cmdAddr == ADDR_W'(k));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          regVal <= '0;
        else if (wantReset) regVal <= '0;
        else if (wrHit)     regVal <= cmdData;
      end
      assign regFlat[k*DATA_W +: DATA_W] = regVal;
    end
  endgenerate

  // Shift register: serial capture, or reload with a read response.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (doRead) begin
      shReg <= {cmdAddr, 1'b1, 1'b0, rdData};
    end else if (st.shiftEn) begin
      shReg <= {shReg[FRAME_BITS-2:0], sIn};
    end
  end

  // Output bit and pad enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut   <= 1'b0;
      serOutEn <= 1'b0;
    end else begin
      if (st.frameStart || st.outUpd) serOut <= shReg[FRAME_BITS-1];
      if (st.frameStart)    serOutEn <= 1'b1;
      else if (st.frameEnd) serOutEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swResetPulse <= 1'b0;
    else       swResetPulse <= wantReset;
  end

endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile
  import ctlport_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter int SYNC_STAGES = 2,
  parameter int SRST_ADDR = 0,
  parameter int SRST_BIT = 9,
  localparam int FRAME_BITS = ADDR_W + 2 + DATA_W,
  localparam int NUM_REGS = 1 << ADDR_W,
  localparam int FLAT_W = NUM_REGS * DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serFrameN,
  input  logic              serIn,
  output logic              serOut,
  output logic              serOutEn,
  output logic [FLAT_W-1:0] regFlat,
  output logic              swResetPulse
);

  logic [2:0]       syncOut;
  ctl_strobe_t      st;
  logic [CNT_W-1:0] bitCnt;

  // Pin order in the synchronizer: {frame, clock, data}; frame idles high.
  ctlport_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serFrameN, serClk, serIn}),
    .dout(syncOut)
  );

  ctlport_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sClk   (syncOut[1]),
    .sFrameN(syncOut[2]),
    .st     (st),
    .bitCnt (bitCnt)
  );

  ctlport_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SRST_ADDR(SRST_ADDR),
    .SRST_BIT (SRST_BIT)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .sIn         (syncOut[0]),
    .serOut      (serOut),
    .serOutEn    (serOutEn),
    .regFlat     (regFlat),
    .swResetPulse(swResetPulse)
  );

endmodule

// File: rtl/ctlport_regfile_chk.sv
module ctlport_regfile_chk #(
  parameter int FLAT_W = 160,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              serOut,
  input logic              serOutEn,
  input logic [FLAT_W-1:0] regFlat,
  input logic              swResetPulse,
  input logic [CNT_W-1:0]  bitCnt
);

  AST_REGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!serOutEn && !$past(serOutEn)) |-> $stable(regFlat)); // R5

  AST_OUT_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !serOutEn |-> $stable(serOut)); // R5

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> (regFlat == '0)); // R8

  AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> !swResetPulse); // R8

  AST_SRST_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> !serOutEn); // R8

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS)); // R7

endmodule

bind ctlport_regfile ctlport_regfile_chk #(
  .FLAT_W(FLAT_W),
  .FRAME_BITS(FRAME_BITS),
  .CNT_W(CNT_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .serOut      (serOut),
  .serOutEn    (serOutEn),
  .regFlat     (regFlat),
  .swResetPulse(swResetPulse),
  .bitCnt      (bitCnt)
);

// File: tb/ctlport_regfile_tb_top.sv
`timescale 1ns/1ps
module ctlport_regfile_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int SYNC = 2;
  localparam int DW = 10;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serFrameN = 1'b1;
  logic serIn = 1'b0;
  logic serOut;
  logic serOutEn;
  logic [NREG*DW-1:0] regFlat;
  logic swResetPulse;

  int nChecks = 0;
  int nFail = 0;
  int pulseCnt = 0;
  bit cmpOn = 1'b0;
  logic [DW-1:0] expRegs [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlport_regfile #(
    .ADDR_W(4), .DATA_W(DW), .SYNC_STAGES(SYNC), .SRST_ADDR(0), .SRST_BIT(9)
  ) dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serFrameN(serFrameN), .serIn(serIn),
    .serOut(serOut), .serOutEn(serOutEn), .regFlat(regFlat), .swResetPulse(swResetPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit qClk[$], qFrm[$], qSdi[$];
  bit mClkPrev, mFrmPrev, mOut, mOe, mPulse;
  int mCnt;
  logic [15:0] mSh;
  logic [DW-1:0] mRegs [NREG];

  task automatic modelReset();
    qClk = {}; qFrm = {}; qSdi = {};
    for (int i = 0; i < SYNC; i++) begin
      qClk.push_back(1'b0); qFrm.push_back(1'b1); qSdi.push_back(1'b0);
    end
    mClkPrev = 0; mFrmPrev = 1; mOut = 0; mOe = 0; mPulse = 0; mCnt = 0; mSh = '0;
    for (int i = 0; i < NREG; i++) mRegs[i] = '0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit sClk, sFrm, sSdi, act, rise, fall, fStart, fEnd, commit;
      int a;
      sClk = qClk.pop_front(); qClk.push_back(serClk);
      sFrm = qFrm.pop_front(); qFrm.push_back(serFrameN);
      sSdi = qSdi.pop_front(); qSdi.push_back(serIn);
      act = !sFrm;
      rise = sClk && !mClkPrev && act;
      fall = !sClk && mClkPrev && act;
      fStart = act && mFrmPrev;
      fEnd = sFrm && !mFrmPrev;
      commit = fEnd && (mCnt == 16);
      a = int'(mSh[15:12]);
      if (fStart || fall) mOut = mSh[15];
      if (fStart) mOe = 1; else if (fEnd) mOe = 0;
      mPulse = 0;
      if (commit && !mSh[11]) begin
        if (a == 0 && mSh[9]) begin
          for (int i = 0; i < NREG; i++) mRegs[i] = '0;
          mPulse = 1;
        end else mRegs[a] = mSh[9:0];
      end
      if (commit && mSh[11]) mSh = {mSh[15:12], 2'b10, mRegs[a]};
      else if (rise) mSh = {mSh[14:0], sSdi};
      if (fStart) mCnt = rise ? 1 : 0;
      else if (rise && mCnt < 16) mCnt++;
      mClkPrev = sClk; mFrmPrev = sFrm;
    end
  end

  always @(negedge clk) begin
    if (swResetPulse) pulseCnt++;
    if (cmpOn) begin
      check(serOut === mOut, "R4", "model serOut", 64'(serOut), 64'(mOut));
      check(serOutEn === mOe, "R5", "model serOutEn", 64'(serOutEn), 64'(mOe));
      check(swResetPulse === mPulse, "R8", "model pulse", 64'(swResetPulse), 64'(mPulse));
      for (int k = 0; k < NREG; k++)
        check(regFlat[k*DW +: DW] === mRegs[k], "R2", "model register",
              64'(regFlat[k*DW +: DW]), 64'(mRegs[k]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] cmd(input int addr, input bit rd, input bit res,
                                      input logic [DW-1:0] data);
    return {4'(addr), rd, res, data};
  endfunction

  task automatic shiftBits(input logic [63:0] w, input int n, output logic [63:0] cap);
    cap = '0;
    serFrameN = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      serIn = w[i];
      tick(HALF);
      cap[i] = serOut;
      serClk = 1'b1;
      tick(HALF);
      serClk = 1'b0;
    end
  endtask

  task automatic closeFrame();
    tick(HALF);
    serFrameN = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic frame(input logic [63:0] w, input int n, output logic [63:0] cap);
    shiftBits(w, n, cap);
    closeFrame();
  endtask

  function automatic bit regsMatch();
    for (int k = 0; k < NREG; k++)
      if (regFlat[k*DW +: DW] !== expRegs[k]) return 1'b0;
    return 1'b1;
  endfunction

  // ---------------- directed sequence ----------------
  initial begin
    logic [63:0] cap;
    int p0;
    for (int k = 0; k < NREG; k++) expRegs[k] = '0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    cmpOn = 1'b1;

    // R1: reset state
    check(regFlat == '0, "R1", "registers after reset", 64'(regFlat[63:0]), 64'd0);
    check(serOutEn == 1'b0 && serOut == 1'b0, "R1", "output after reset",
          64'({serOutEn, serOut}), 64'd0);
    check(swResetPulse == 1'b0, "R1", "pulse after reset", 64'(swResetPulse), 64'd0);

    // R2/R10: write reg 3, check its field position
    frame(64'(cmd(3, 0, 0, 10'h2A5)), 16, cap);
    expRegs[3] = 10'h2A5;
    check(regFlat[3*DW +: DW] == 10'h2A5, "R10", "reg3 field", 64'(regFlat[3*DW +: DW]), 64'h2A5);
    check(regsMatch(), "R2", "write reg3 only", 64'(regFlat[63:0]), 64'(expRegs[0]));

    // R3: latency from frame close to register update
    shiftBits(64'(cmd(7, 0, 0, 10'h155)), 16, cap);
    tick(HALF);
    serFrameN = 1'b1;
    tick(SYNC);
    check(regFlat[7*DW +: DW] == 10'h000, "R3", "reg7 before latency",
          64'(regFlat[7*DW +: DW]), 64'h0);
    tick(1);
    check(regFlat[7*DW +: DW] == 10'h155, "R3", "reg7 at latency",
          64'(regFlat[7*DW +: DW]), 64'h155);
    tick(2 * HALF);
    expRegs[7] = 10'h155;

    // R9: reserved bit ignored on write
    frame(64'(cmd(12, 0, 1, 10'h3C3)), 16, cap);
    expRegs[12] = 10'h3C3;
    check(regFlat[12*DW +: DW] == 10'h3C3, "R9", "write with reserved set",
          64'(regFlat[12*DW +: DW]), 64'h3C3);

    // R4: read reg 3, response in next frame; R9 read changes nothing
    frame(64'(cmd(3, 1, 0, 10'h000)), 16, cap);
    check(regsMatch(), "R9", "read leaves registers", 64'(regFlat[3*DW +: DW]), 64'(expRegs[3]));
    frame(64'(cmd(7, 1, 0, 10'h000)), 16, cap);
    check(cap[15:0] == {4'd3, 2'b10, 10'h2A5}, "R4", "read response reg3",
          64'(cap[15:0]), 64'({4'd3, 2'b10, 10'h2A5}));
    frame(64'(cmd(0, 1, 0, 10'h000)), 16, cap);
    check(cap[15:0] == {4'd7, 2'b10, 10'h155}, "R4", "read response reg7",
          64'(cap[15:0]), 64'({4'd7, 2'b10, 10'h155}));

    // R5: clock and data toggling while frame is high are ignored
    frame(64'(cmd(12, 1, 0, 10'h000)), 16, cap);
    for (int i = 0; i < 20; i++) begin
      serIn = i[0];
      serClk = 1'b1;
      tick(HALF);
      check(serOutEn == 1'b0, "R5", "enable low while idle", 64'(serOutEn), 64'd0);
      serClk = 1'b0;
      tick(HALF);
    end
    check(regsMatch(), "R5", "registers after idle activity", 64'(regFlat[63:0]), 64'(expRegs[0]));
    frame(64'(cmd(3, 1, 0, 10'h000)), 16, cap);
    check(cap[15:0] == {4'd12, 2'b10, 10'h3C3}, "R5", "pending response kept",
          64'(cap[15:0]), 64'({4'd12, 2'b10, 10'h3C3}));

    // R6: short frame discarded
    frame(64'(10'b0101_0_0_1111), 10, cap);
    check(regsMatch(), "R6", "short frame ignored", 64'(regFlat[63:0]), 64'(expRegs[0]));

    // R7: 32-bit frame, last 16 bits decoded, first 16 pass through
    frame({32'd0, 16'hA5C3, cmd(9, 0, 0, 10'h0F0)}, 32, cap);
    expRegs[9] = 10'h0F0;
    check(regFlat[9*DW +: DW] == 10'h0F0, "R7", "long frame decode",
          64'(regFlat[9*DW +: DW]), 64'h0F0);
    check(regsMatch(), "R7", "long frame only reg9", 64'(regFlat[63:0]), 64'(expRegs[0]));
    check(cap[15:0] == 16'hA5C3, "R7", "pass-through delay 16",
          64'(cap[15:0]), 64'hA5C3);

    // R8: soft reset clears everything, one pulse
    p0 = pulseCnt;
    frame(64'(cmd(0, 0, 0, 10'h200)), 16, cap);
    for (int k = 0; k < NREG; k++) expRegs[k] = '0;
    check(regFlat == '0, "R8", "soft reset clears", 64'(regFlat[63:0]), 64'd0);
    check(pulseCnt - p0 == 1, "R8", "single pulse", 64'(pulseCnt - p0), 64'd1);
    frame(64'(cmd(0, 1, 0, 10'h000)), 16, cap);
    frame(64'(cmd(0, 1, 0, 10'h000)), 16, cap);
    check(cap[15:0] == {4'd0, 2'b10, 10'h000}, "R8", "soft reset bit self-clears",
          64'(cap[15:0]), 64'({4'd0, 2'b10, 10'h000}));

    // R8: write to register 0 without the reset bit is a plain write
    p0 = pulseCnt;
    frame(64'(cmd(0, 0, 0, 10'h1FF)), 16, cap);
    expRegs[0] = 10'h1FF;
    check(regFlat[DW-1:0] == 10'h1FF && pulseCnt == p0, "R8", "plain write reg0",
          64'(regFlat[DW-1:0]), 64'h1FF);

    // R2: write to top address
    frame(64'(cmd(15, 0, 0, 10'h3FF)), 16, cap);
    expRegs[15] = 10'h3FF;
    check(regsMatch(), "R2", "write reg15", 64'(regFlat[15*DW +: DW]), 64'h3FF);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule